// File: doc/BRIEF.md
# Serial Addressed Control Latch Array

This block takes a three-wire serial control stream (serial clock, serial data, strobe) and turns each transfer into a single-bit write to a bank of addressed latches. Every transfer is seven bits long: a six-bit address, most significant bit first, followed by one data bit. When the strobe rises, the latch named by the address takes the data bit. Address zero is reserved as a clear command that empties the whole bank.

The latch bank drives an audio crosspoint matrix and a set of mode controls. Each crosspoint route has its own latch, so one output can have several sources enabled together. Seven fixed addresses also select the mode controls: record amplifier on, playback amplifier on, two receiver volume boosts, handset receiver mute, loudspeaker gain reduction and microphone mute. The serial pins are asynchronous to the system clock. They are synchronized, and their edges are found in the system clock domain. The system clock must run at least eight times faster than the serial clock.

Top module: `serial_latch_ctrl`

## Requirements
- R1: After reset is asserted, every bit of the latch vector and every mode control output is 0.
- R2: On each rising edge of the serial clock, the synchronized data bit is shifted into the low end of a 7-bit word. The upper six bits of the word are the address (first bit sent = address MSB) and bit 0 is the data bit. The sequence 1,0,0,1,1,0,1 therefore writes 1 to address 0x26.
- R3: While the strobe does not rise, the latch vector does not change, however many bits are shifted.
- R4: On a strobe rising edge with a nonzero address and data bit 1, the addressed latch becomes 1 and no other latch changes.
- R5: On a strobe rising edge with a nonzero address and data bit 0, the addressed latch becomes 0 and no other latch changes.
- R6: On a strobe rising edge with address 0x00, every latch becomes 0, whatever the data bit.
- R7: The mode outputs follow their latches: rec_amp_on = latch 0x07, play_amp_on = latch 0x0F, handset_mute = latch 0x27, spk_gain_cut = latch 0x2F, mic_mute = latch 0x3F.
- R8: rx_boost is 2'b00 with neither boost latch set, 2'b01 (+6 dB) when only latch 0x17 is set, and 2'b10 (+9 dB) whenever latch 0x1F is set. It is never 2'b11.
- R9: Any number of crosspoint latches can be set at once. For example, latches 0x38 through 0x3E can all be 1 together.
- R10: A write to an address with no mode function (for example 0x01) is stored in the latch vector and leaves every mode output unchanged.
- R11: A strobe held high performs only one write. Bits shifted while it stays high, and its falling edge, change no latch until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on clear) |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_stb | input | 1 | Strobe; a rising edge commits the shifted word |
| latch_q | output | 64 | Full latch bank, bit n = address n |
| rec_amp_on | output | 1 | Record amplifier enable |
| play_amp_on | output | 1 | Playback amplifier enable |
| rx_boost | output | 2 | Receiver volume code: 00 flat, 01 +6 dB, 10 +9 dB |
| handset_mute | output | 1 | Handset receiver mute |
| spk_gain_cut | output | 1 | Loudspeaker output gain reduced by 12 dB |
| mic_mute | output | 1 | Microphone preamplifier mute |

## Verification
The assertions check the cycle-level rules on every clock. Each detected serial clock edge must shift exactly the synchronized data bit into the word. Without a strobe edge the latch vector must stay constant. A strobe edge must set, clear or wipe the bank exactly as the strobed word says. The volume code must never take its unused value. Only the bench's scenarios can show the end-to-end behaviour across the pins: the documented example sequence, the mixing of several routes, the mode outputs for each reserved address, and the single write from a strobe that is held high.

// File: rtl/slc_pkg.sv
package slc_pkg;

  localparam int ADDR_BITS = 6;

  localparam logic [ADDR_BITS-1:0] ADR_CLEAR    = 6'h00;
  localparam logic [ADDR_BITS-1:0] ADR_REC_ON   = 6'h07;
  localparam logic [ADDR_BITS-1:0] ADR_PLAY_ON  = 6'h0F;
  localparam logic [ADDR_BITS-1:0] ADR_BOOST6   = 6'h17;
  localparam logic [ADDR_BITS-1:0] ADR_BOOST9   = 6'h1F;
  localparam logic [ADDR_BITS-1:0] ADR_HS_MUTE  = 6'h27;
  localparam logic [ADDR_BITS-1:0] ADR_SPK_CUT  = 6'h2F;
  localparam logic [ADDR_BITS-1:0] ADR_MIC_MUTE = 6'h3F;

  typedef enum logic [1:0] {
    BOOST_NONE = 2'b00,
    BOOST_6DB  = 2'b01,
    BOOST_9DB  = 2'b10
  } boost_e;

  // The larger boost wins when both latches are set.
  function automatic boost_e boost_select(input logic b6, input logic b9);
    if (b9)      return BOOST_9DB;
    else if (b6) return BOOST_6DB;
    else         return BOOST_NONE;
  endfunction

endpackage

// File: rtl/slc_pin_sync.sv
module slc_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] chain [STAGES];
  logic [WIDTH-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain[STAGES-1];
  end

  assign lvl_o  = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev_q;

endmodule

// File: rtl/slc_shift_word.sv
module slc_shift_word #(
  parameter int WORD_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_o <= '0;
    else if (shift_en) word_o <= {word_o[WORD_W-2:0], bit_i};
  end

endmodule

// File: rtl/slc_latch_bank.sv
module slc_latch_bank #(
  parameter int ADDR_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic                   wr_dat,
  output logic [(1<<ADDR_W)-1:0] bank_o
);

  localparam int ENTRIES = 1 << ADDR_W;

  logic clr_all;
  assign clr_all = (wr_addr == '0);

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(e);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bank_o[e] <= 1'b0;
        end else if (wr_en) begin
          if (clr_all)                 bank_o[e] <= 1'b0;
          else if (wr_addr == MY_ADDR) bank_o[e] <= wr_dat;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/slc_mode_decode.sv
module slc_mode_decode
  import slc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [(1<<ADDR_W)-1:0] bank_i,
  output logic                   rec_amp_on,
  output logic                   play_amp_on,
  output logic [1:0]             rx_boost,
  output logic                   handset_mute,
  output logic                   spk_gain_cut,
  output logic                   mic_mute
);

  boost_e boost;

  always_comb begin
    rec_amp_on   = bank_i[ADR_REC_ON];
    play_amp_on  = bank_i[ADR_PLAY_ON];
    handset_mute = bank_i[ADR_HS_MUTE];
    spk_gain_cut = bank_i[ADR_SPK_CUT];
    mic_mute     = bank_i[ADR_MIC_MUTE];
    boost        = boost_select(bank_i[ADR_BOOST6], bank_i[ADR_BOOST9]);
    rx_boost     = boost;
  end

endmodule

// File: rtl/serial_latch_ctrl.sv
module serial_latch_ctrl #(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk,
  input  logic                   ser_dat,
  input  logic                   ser_stb,
  output logic [(1<<ADDR_W)-1:0] latch_q,
  output logic                   rec_amp_on,
  output logic                   play_amp_on,
  output logic [1:0]             rx_boost,
  output logic                   handset_mute,
  output logic                   spk_gain_cut,
  output logic                   mic_mute
);

  localparam int WORD_W = ADDR_W + 1;
  localparam int P_CLK  = 0;
  localparam int P_DAT  = 1;
  localparam int P_STB  = 2;

  logic [2:0]        pin_lvl;
  logic [2:0]        pin_rise;
  logic              sclk_rise;
  logic              stb_rise;
  logic              dat_lvl;
  logic [WORD_W-1:0] word_q;

  slc_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({ser_stb, ser_dat, ser_clk}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise)
  );

  assign sclk_rise = pin_rise[P_CLK];
  assign stb_rise  = pin_rise[P_STB];
  assign dat_lvl   = pin_lvl[P_DAT];

  slc_shift_word #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sclk_rise),
    .bit_i    (dat_lvl),
    .word_o   (word_q)
  );

  slc_latch_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (stb_rise),
    .wr_addr (word_q[WORD_W-1:1]),
    .wr_dat  (word_q[0]),
    .bank_o  (latch_q)
  );

  slc_mode_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bank_i       (latch_q),
    .rec_amp_on   (rec_amp_on),
    .play_amp_on  (play_amp_on),
    .rx_boost     (rx_boost),
    .handset_mute (handset_mute),
    .spk_gain_cut (spk_gain_cut),
    .mic_mute     (mic_mute)
  );

endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
  parameter int ADDR_W = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sclk_rise,
  input logic                   stb_rise,
  input logic                   dat_lvl,
  input logic [ADDR_W:0]        word_q,
  input logic [(1<<ADDR_W)-1:0] latch_q,
  input logic [1:0]             rx_boost
);

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> word_q == {$past(word_q[ADDR_W-1:0]), $past(dat_lvl)});

  assert_hold_without_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_rise |=> $stable(latch_q));

  assert_set_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && word_q[ADDR_W:1] != '0 && word_q[0]) |=>
      latch_q[$past(word_q[ADDR_W:1])] == 1'b1);

  assert_clear_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && word_q[ADDR_W:1] != '0 && !word_q[0]) |=>
      latch_q[$past(word_q[ADDR_W:1])] == 1'b0);

  assert_global_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && word_q[ADDR_W:1] == '0) |=> latch_q == '0);

  assert_boost_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_boost != 2'b11);

endmodule

bind serial_latch_ctrl slc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk_rise (sclk_rise),
  .stb_rise  (stb_rise),
  .dat_lvl   (dat_lvl),
  .word_q    (word_q),
  .latch_q   (latch_q),
  .rx_boost  (rx_boost)
);

// File: tb/serial_latch_ctrl_test.sv
module serial_latch_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SER   = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic        ser_stb = 1'b0;
  logic [63:0] latch_q;
  logic        rec_amp_on, play_amp_on, handset_mute, spk_gain_cut, mic_mute;
  logic [1:0]  rx_boost;

  logic [63:0] exp_bank = '0;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_latch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb),
    .latch_q(latch_q), .rec_amp_on(rec_amp_on), .play_amp_on(play_amp_on),
    .rx_boost(rx_boost), .handset_mute(handset_mute), .spk_gain_cut(spk_gain_cut),
    .mic_mute(mic_mute)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [1:0] ev;
    ev = exp_bank[8'h1F] ? 2'b10 : (exp_bank[8'h17] ? 2'b01 : 2'b00);
    check(req, "latch_q", latch_q, exp_bank);
    check(req, "modes",
          {58'd0, rec_amp_on, play_amp_on, handset_mute, spk_gain_cut, mic_mute, 1'b0},
          {58'd0, exp_bank[8'h07], exp_bank[8'h0F], exp_bank[8'h27], exp_bank[8'h2F],
           exp_bank[8'h3F], 1'b0});
    check(req, "rx_boost", {62'd0, rx_boost}, {62'd0, ev});
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_dat = b;
    wait_clks(HALF_SER);
    ser_clk = 1'b1;
    wait_clks(HALF_SER);
    ser_clk = 1'b0;
  endtask

  task automatic shift_word(input logic [5:0] a, input logic d);
    for (int i = 5; i >= 0; i--) shift_bit(a[i]);
    shift_bit(d);
  endtask

  task automatic pulse_strobe();
    ser_stb = 1'b1;
    wait_clks(HALF_SER);
    ser_stb = 1'b0;
    wait_clks(HALF_SER);
  endtask

  task automatic model_write(input logic [5:0] a, input logic d);
    if (a == 6'h00) exp_bank = '0;
    else            exp_bank[a] = d;
  endtask

  task automatic write_word(input logic [5:0] a, input logic d);
    shift_word(a, d);
    pulse_strobe();
    model_write(a, d);
  endtask

  task automatic t_reset_R1();
    rst_n = 1'b0;
    wait_clks(4);
    exp_bank = '0;
    check_all("R1");
    rst_n = 1'b1;
    wait_clks(4);
    check_all("R1");
  endtask

  task automatic t_example_R2();
    // bits 1,0,0,1,1,0,1 -> address 0x26, data 1
    shift_bit(1); shift_bit(0); shift_bit(0); shift_bit(1);
    shift_bit(1); shift_bit(0); shift_bit(1);
    pulse_strobe();
    exp_bank[8'h26] = 1'b1;
    check("R2", "bit26", {63'd0, latch_q[8'h26]}, 64'd1);
    check_all("R4");
  endtask

  task automatic t_no_strobe_R3();
    shift_word(6'h10, 1'b1);
    wait_clks(6);
    check_all("R3");
    shift_word(6'h11, 1'b1);
    wait_clks(6);
    check_all("R3");
    pulse_strobe();
    model_write(6'h11, 1'b1);
    check_all("R3");
  endtask

  task automatic t_clear_one_R5();
    write_word(6'h26, 1'b0);
    check("R5", "bit26", {63'd0, latch_q[8'h26]}, 64'd0);
    check_all("R5");
  endtask

  task automatic t_modes_R7();
    logic [5:0] m [5] = '{6'h07, 6'h0F, 6'h27, 6'h2F, 6'h3F};
    foreach (m[k]) begin
      write_word(m[k], 1'b1);
      check_all("R7");
    end
    foreach (m[k]) begin
      write_word(m[k], 1'b0);
      check_all("R7");
    end
  endtask

  task automatic t_boost_R8();
    write_word(6'h17, 1'b1);
    check("R8", "boost6", {62'd0, rx_boost}, 64'd1);
    write_word(6'h1F, 1'b1);
    check("R8", "both", {62'd0, rx_boost}, 64'd2);
    write_word(6'h17, 1'b0);
    check("R8", "boost9", {62'd0, rx_boost}, 64'd2);
    write_word(6'h1F, 1'b0);
    check("R8", "none", {62'd0, rx_boost}, 64'd0);
  endtask

  task automatic t_mix_R9();
    for (int a = 8'h38; a <= 8'h3E; a++) write_word(6'(a), 1'b1);
    check("R9", "aux routes", {57'd0, latch_q[8'h3E:8'h38]}, {57'd0, 7'h7F});
    check_all("R9");
  endtask

  task automatic t_unassigned_R10();
    write_word(6'h01, 1'b1);
    check("R10", "bit01", {63'd0, latch_q[1]}, 64'd1);
    check_all("R10");
  endtask

  task automatic t_held_strobe_R11();
    shift_word(6'h21, 1'b1);
    ser_stb = 1'b1;
    wait_clks(HALF_SER);
    model_write(6'h21, 1'b1);
    check_all("R11");
    shift_word(6'h22, 1'b1);
    wait_clks(6);
    check_all("R11");
    ser_stb = 1'b0;
    wait_clks(6);
    check_all("R11");
    pulse_strobe();
    model_write(6'h22, 1'b1);
    check_all("R11");
  endtask

  task automatic t_global_clear_R6();
    write_word(6'h07, 1'b1);
    write_word(6'h3F, 1'b1);
    check_all("R6");
    write_word(6'h00, 1'b1);
    check("R6", "bank", latch_q, 64'd0);
    check_all("R6");
  endtask

  initial begin
    t_reset_R1();
    t_example_R2();
    t_no_strobe_R3();
    t_clear_one_R5();
    t_modes_R7();
    t_boost_R8();
    t_mix_R9();
    t_unassigned_R10();
    t_held_strobe_R11();
    t_global_clear_R6();
    t_reset_R1();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule